// File: doc/BRIEF.md
# Banked Register File with Data-Memory Alias

This block holds the working registers of a small 8-bit processor core. Storage is four banks of eight byte-wide registers, 32 bytes in all. The core reaches the registers by name through a CPU-side port. That port reads or writes one byte, or one 16-bit pair, in whichever bank is currently selected. A 2-bit bank-select register chooses the bank. A select-bank command loads it, so that normal code and interrupt handlers can each keep a private set of registers.

The same 32 bytes also appear in data memory through a second, byte-wide port, in a fixed window from FEE0h to FEFFh. Bank 0 sits at the top of the window, and each higher-numbered bank lies eight bytes lower. Software can therefore inspect or preload any bank by address without switching to it. Both ports read combinationally from the registered array. A write on either port is seen by reads from the next cycle onward.

Top module: `banked_regfile`

## Requirements
- R1: While reset is high, the bank select goes to 0 and all 32 bytes go to zero; after reset, every register reads 00h on both ports.
- R2: A select-bank command (sel_we=1) loads sel_bank into the bank select at the clock edge. Without a command the bank select holds its value. A register access in the same cycle as the command still uses the old bank.
- R3: A byte access (cpu_wide=0) addresses register Rk, where k=cpu_idx, of the current bank. The register numbers 0..7 correspond to X, A, C, B, E, D, L, H. The read returns the byte on cpu_rdata[7:0], with cpu_rdata[15:8]=00h.
- R4: A pair access (cpu_wide=1) addresses pair p=cpu_idx[2:1] (0=AX, 1=BC, 2=DE, 3=HL). The low byte is R(2p) and the high byte is R(2p+1). cpu_idx[0] is ignored.
- R5: A byte write changes only the addressed register of the current bank.
- R6: A pair write updates both bytes of the pair at the same clock edge: the low byte from cpu_wdata[7:0] and the high byte from cpu_wdata[15:8].
- R7: On the memory port, register Rk of bank n is at address FEF8h − 8·n + k. For those addresses mem_hit=1, and mem_rdata returns that byte.
- R8: An address outside FEE0h..FEFFh gives mem_hit=0 and mem_rdata=00h, and a write to it changes no register.
- R9: When both ports write the same byte in one cycle, the CPU-side value is stored.
- R10: A memory-port write to any bank is returned by a later register-name read once that bank is selected, and the reverse also holds.
- R11: Reads are combinational from the array, so a write is visible on both ports in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Select-bank command strobe |
| sel_bank | input | 2 | Bank number for the command |
| cur_bank | output | 2 | Currently selected bank |
| cpu_we | input | 1 | CPU-side write enable |
| cpu_wide | input | 1 | 1 = 16-bit pair access, 0 = byte access |
| cpu_idx | input | 3 | Register number (byte) or pair number in bits 2:1 |
| cpu_wdata | input | 16 | CPU-side write data (byte uses bits 7:0) |
| cpu_rdata | output | 16 | CPU-side read data |
| mem_addr | input | 16 | Data-memory address |
| mem_we | input | 1 | Data-memory write enable |
| mem_wdata | input | 8 | Data-memory write data |
| mem_rdata | output | 8 | Data-memory read data, 00h on a miss |
| mem_hit | output | 1 | Address lies in the register window |

## Verification
The bench aims at the address arithmetic at the edges of the window. It uses FEDFh and FF00h just outside, and FEE0h and FEFFh just inside. A decoder that reversed the bank stacking or was off by one would return the wrong byte, or would assert a hit there. It writes every bank through memory and reads each one back by name after selecting it, which exposes a bank index that is ignored or inverted. It drives colliding writes from both ports to show which port wins, and issues a bank-select command in the same cycle as an access to show which bank that access uses. Long pseudo-random runs compare every output against a behavioural model on every clock, to expose a pair write that lands only one byte or a byte write that spills into its neighbour.

// File: rtl/brf_pkg.sv
package brf_pkg;
  // Register numbers within a bank, by function name.
  typedef enum logic [2:0] {
    REG_X = 3'd0, REG_A = 3'd1, REG_C = 3'd2, REG_B = 3'd3,
    REG_E = 3'd4, REG_D = 3'd5, REG_L = 3'd6, REG_H = 3'd7
  } reg_name_e;

  // Pair numbers (selected by cpu_idx[2:1]).
  typedef enum logic [1:0] {
    PAIR_AX = 2'd0, PAIR_BC = 2'd1, PAIR_DE = 2'd2, PAIR_HL = 2'd3
  } pair_name_e;

  // One byte-wide write request into the flat array.
  typedef struct packed {
    logic       en;
    logic [4:0] idx;
    logic [7:0] data;
  } byte_wr_t;
endpackage

// File: rtl/rf_mem_decode.sv
module rf_mem_decode #(
  parameter int AW    = 16,
  parameter int BANKS = 4,
  parameter int REGS  = 8,
  parameter logic [AW-1:0] BASE = 16'hFEE0,
  localparam int BYTES = BANKS * REGS,
  localparam int IDXW  = $clog2(BYTES),
  localparam int RW    = $clog2(REGS),
  localparam int BW    = $clog2(BANKS)
) (
  input  logic [AW-1:0]   addr,
  output logic            hit,
  output logic [IDXW-1:0] flat_idx
);
  logic [AW-1:0] off;
  logic [BW-1:0] slot_from_top;
  logic [BW-1:0] bank;

  always_comb begin
    off           = addr - BASE;
    hit           = (addr >= BASE) && (off < AW'(BYTES));
    slot_from_top = off[IDXW-1:RW];
    // Bank 0 at the top of the window, higher banks stacked downward.
    bank          = BW'(BANKS - 1) - slot_from_top;
    flat_idx      = {bank, off[RW-1:0]};
  end
endmodule

// File: rtl/rf_cpu_decode.sv
module rf_cpu_decode #(
  parameter int BANKS = 4,
  parameter int REGS  = 8,
  localparam int BYTES = BANKS * REGS,
  localparam int IDXW  = $clog2(BYTES),
  localparam int RW    = $clog2(REGS),
  localparam int BW    = $clog2(BANKS)
) (
  input  logic [BW-1:0]   bank,
  input  logic [RW-1:0]   idx,
  input  logic            wide,
  output logic [IDXW-1:0] lo_idx,
  output logic [IDXW-1:0] hi_idx
);
  logic [RW-1:0] lo_reg;
  logic [RW-1:0] hi_reg;

  always_comb begin
    lo_reg = wide ? {idx[RW-1:1], 1'b0} : idx;
    hi_reg = {idx[RW-1:1], 1'b1};
    lo_idx = {bank, lo_reg};
    hi_idx = {bank, hi_reg};
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int BYTES = 32,
  parameter int DW    = 8,
  localparam int IDXW = $clog2(BYTES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lo_we,
  input  logic [IDXW-1:0] lo_idx,
  input  logic [DW-1:0]   lo_data,
  input  logic            hi_we,
  input  logic [IDXW-1:0] hi_idx,
  input  logic [DW-1:0]   hi_data,
  input  logic            m_we,
  input  logic [IDXW-1:0] m_idx,
  input  logic [DW-1:0]   m_data,
  output logic [DW-1:0]   rd_lo,
  output logic [DW-1:0]   rd_hi,
  output logic [DW-1:0]   rd_m
);
  logic [DW-1:0] arr [BYTES];

  // CPU-side byte lanes take priority over the memory-side lane.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < BYTES; i++) arr[i] <= '0;
    end else begin
      for (int i = 0; i < BYTES; i++) begin
        if (lo_we && lo_idx == IDXW'(i))      arr[i] <= lo_data;
        else if (hi_we && hi_idx == IDXW'(i)) arr[i] <= hi_data;
        else if (m_we && m_idx == IDXW'(i))   arr[i] <= m_data;
      end
    end
  end

  assign rd_lo = arr[lo_idx];
  assign rd_hi = arr[hi_idx];
  assign rd_m  = arr[m_idx];

  // R9: on a same-byte collision the CPU value is stored.
  p_cpu_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (lo_we && m_we && lo_idx == m_idx) |=> arr[$past(m_idx)] == $past(lo_data));

  // R6: a pair write lands both bytes at one edge.
  p_pair_both_r6: assert property (@(posedge clk) disable iff (rst)
    (lo_we && hi_we) |=> (arr[$past(lo_idx)] == $past(lo_data)) &&
                         (arr[$past(hi_idx)] == $past(hi_data)));

  // R7: an uncontested memory-side write is stored.
  p_mem_lands_r7: assert property (@(posedge clk) disable iff (rst)
    (m_we && !(lo_we && lo_idx == m_idx) && !(hi_we && hi_idx == m_idx))
      |=> arr[$past(m_idx)] == $past(m_data));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int AW    = 16,
  parameter int BANKS = 4,
  parameter int REGS  = 8,
  parameter int DW    = 8,
  parameter logic [AW-1:0] BASE = 16'hFEE0,
  localparam int BYTES = BANKS * REGS,
  localparam int IDXW  = $clog2(BYTES),
  localparam int RW    = $clog2(REGS),
  localparam int BW    = $clog2(BANKS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_we,
  input  logic [BW-1:0]   sel_bank,
  output logic [BW-1:0]   cur_bank,
  input  logic            cpu_we,
  input  logic            cpu_wide,
  input  logic [RW-1:0]   cpu_idx,
  input  logic [2*DW-1:0] cpu_wdata,
  output logic [2*DW-1:0] cpu_rdata,
  input  logic [AW-1:0]   mem_addr,
  input  logic            mem_we,
  input  logic [DW-1:0]   mem_wdata,
  output logic [DW-1:0]   mem_rdata,
  output logic            mem_hit
);
  logic [BW-1:0]   bank_q;
  logic [IDXW-1:0] lo_idx, hi_idx, m_idx;
  logic [DW-1:0]   rd_lo, rd_hi, rd_m;
  logic            m_hit;

  always_ff @(posedge clk) begin
    if (rst)         bank_q <= '0;
    else if (sel_we) bank_q <= sel_bank;
  end
  assign cur_bank = bank_q;

  rf_cpu_decode #(.BANKS(BANKS), .REGS(REGS)) u_cpu_dec (
    .bank   (bank_q),
    .idx    (cpu_idx),
    .wide   (cpu_wide),
    .lo_idx (lo_idx),
    .hi_idx (hi_idx)
  );

  rf_mem_decode #(.AW(AW), .BANKS(BANKS), .REGS(REGS), .BASE(BASE)) u_mem_dec (
    .addr     (mem_addr),
    .hit      (m_hit),
    .flat_idx (m_idx)
  );

  rf_storage #(.BYTES(BYTES), .DW(DW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .lo_we   (cpu_we),
    .lo_idx  (lo_idx),
    .lo_data (cpu_wdata[DW-1:0]),
    .hi_we   (cpu_we && cpu_wide),
    .hi_idx  (hi_idx),
    .hi_data (cpu_wdata[2*DW-1:DW]),
    .m_we    (mem_we && m_hit),
    .m_idx   (m_idx),
    .m_data  (mem_wdata),
    .rd_lo   (rd_lo),
    .rd_hi   (rd_hi),
    .rd_m    (rd_m)
  );

  assign cpu_rdata = cpu_wide ? {rd_hi, rd_lo} : {{DW{1'b0}}, rd_lo};
  assign mem_hit   = m_hit;
  assign mem_rdata = m_hit ? rd_m : '0;

  // R2: a command loads the bank select at the next edge.
  p_bank_load_r2: assert property (@(posedge clk) disable iff (rst)
    sel_we |=> cur_bank == $past(sel_bank));

  // R2: without a command the bank select holds.
  p_bank_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !sel_we |=> $stable(cur_bank));
endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_we = 1'b0;
  logic [1:0]  sel_bank = '0;
  logic [1:0]  cur_bank;
  logic        cpu_we = 1'b0, cpu_wide = 1'b0;
  logic [2:0]  cpu_idx = '0;
  logic [15:0] cpu_wdata = '0, cpu_rdata;
  logic [15:0] mem_addr = '0;
  logic        mem_we = 1'b0;
  logic [7:0]  mem_wdata = '0, mem_rdata;
  logic        mem_hit;

  always #2 clk = ~clk;

  banked_regfile dut (.*);

  int ref_mem [32];
  int ref_bank;
  int checks = 0, fails = 0;

  function automatic int map_idx(input logic [15:0] a);
    int off;
    if (a < 16'hFEE0 || a > 16'hFEFF) return -1;
    off = int'(a) - 'hFEE0;
    return (3 - off / 8) * 8 + off % 8;
  endfunction

  task automatic chk(input string tag, input string sig, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %h exp %h", tag, sig, got, exp);
    end
  endtask

  task automatic compare(input string tag);
    int mi, lo, e;
    lo = ref_bank * 8 + (cpu_wide ? (cpu_idx & 6) : cpu_idx);
    e  = cpu_wide ? (ref_mem[lo + (cpu_idx & 1 ? 0 : 1)] << 8 | ref_mem[lo]) : ref_mem[lo];
    if (cpu_wide) e = (ref_mem[ref_bank*8 + (cpu_idx & 6) + 1] << 8) | ref_mem[lo];
    chk(tag, "cpu_rdata", int'(cpu_rdata), e);
    mi = map_idx(mem_addr);
    chk(tag, "mem_hit", int'(mem_hit), mi >= 0 ? 1 : 0);
    chk(tag, "mem_rdata", int'(mem_rdata), mi >= 0 ? ref_mem[mi] : 0);
    chk(tag, "cur_bank", int'(cur_bank), ref_bank);
  endtask

  task automatic model_edge();
    int mi;
    if (rst) begin
      foreach (ref_mem[i]) ref_mem[i] = 0;
      ref_bank = 0;
      return;
    end
    mi = map_idx(mem_addr);
    if (mem_we && mi >= 0) ref_mem[mi] = mem_wdata;
    if (cpu_we) begin
      if (cpu_wide) begin
        ref_mem[ref_bank*8 + (cpu_idx & 6)]     = cpu_wdata[7:0];
        ref_mem[ref_bank*8 + (cpu_idx & 6) + 1] = cpu_wdata[15:8];
      end else ref_mem[ref_bank*8 + cpu_idx] = cpu_wdata[7:0];
    end
    if (sel_we) ref_bank = sel_bank;
  endtask

  // Inputs are set at the falling edge; outputs are sampled 1 ns later.
  task automatic tick(input string tag);
    #1;
    if (!rst) compare(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    sel_we = 0; cpu_we = 0; mem_we = 0; cpu_wide = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    foreach (ref_mem[i]) ref_mem[i] = 'hA5;
    ref_bank = 3;
    @(negedge clk);
    rst = 1; tick("R1"); tick("R1");
    rst = 0;
    // R1: every byte reads zero after reset, through both ports
    for (int a = 'hFEE0; a <= 'hFEFF; a++) begin
      mem_addr = 16'(a); cpu_idx = 3'(a & 7); tick("R1");
    end
    // R3 R5: byte writes to bank 0, each register in turn, then read back
    for (int k = 0; k < 8; k++) begin
      idle(); cpu_we = 1; cpu_idx = 3'(k); cpu_wdata = 16'(16'hBE00 | (k * 17 + 1));
      mem_addr = 16'(16'hFEF8 + k); tick("R5");
      idle(); tick("R11");
      for (int j = 0; j < 8; j++) begin cpu_idx = 3'(j); tick("R3"); end
    end
    // R4 R6: pair writes and pair reads, both values of cpu_idx[0]
    for (int p = 0; p < 4; p++) begin
      idle(); cpu_we = 1; cpu_wide = 1; cpu_idx = 3'(p * 2 + 1);
      cpu_wdata = 16'(16'h1234 + p * 16'h1111); tick("R6");
      idle(); cpu_wide = 1; cpu_idx = 3'(p * 2); tick("R4");
      cpu_idx = 3'(p * 2 + 1); tick("R4");
      cpu_wide = 0; cpu_idx = 3'(p * 2 + 1); tick("R3");
    end
    // R7 R10: fill every bank through memory, read by name after selecting
    for (int a = 'hFEE0; a <= 'hFEFF; a++) begin
      idle(); mem_we = 1; mem_addr = 16'(a); mem_wdata = 8'(a ^ 'h3C); tick("R7");
    end
    for (int b = 0; b < 4; b++) begin
      idle(); sel_we = 1; sel_bank = 2'(b); tick("R2");
      idle();
      for (int k = 0; k < 8; k++) begin
        cpu_idx = 3'(k); mem_addr = 16'(16'hFEF8 - 8 * b + k); tick("R10");
      end
      cpu_we = 1; cpu_idx = 3'd7; cpu_wdata = 16'(8'h70 + b); tick("R10");
      idle(); mem_addr = 16'(16'hFEFF - 8 * b); tick("R10");
    end
    // R8: writes just outside and far outside the window change nothing
    foreach (ref_mem[i]) ;
    for (int t = 0; t < 4; t++) begin
      idle(); mem_we = 1; mem_wdata = 8'hEE;
      mem_addr = (t == 0) ? 16'hFEDF : (t == 1) ? 16'hFF00 : (t == 2) ? 16'h0000 : 16'hFFFF;
      tick("R8");
    end
    idle();
    for (int a = 'hFEE0; a <= 'hFEFF; a++) begin mem_addr = 16'(a); tick("R8"); end
    // R9: both ports write the same byte; also a pair write colliding on its high byte
    idle(); sel_we = 1; sel_bank = 2'd2; tick("R2");
    idle(); cpu_we = 1; cpu_idx = 3'd4; cpu_wdata = 16'h00C9;
    mem_we = 1; mem_addr = 16'hFEEC; mem_wdata = 8'h9C; tick("R9");
    idle(); cpu_idx = 3'd4; mem_addr = 16'hFEEC; tick("R9");
    cpu_we = 1; cpu_wide = 1; cpu_idx = 3'd6; cpu_wdata = 16'hABCD;
    mem_we = 1; mem_addr = 16'hFEEF; mem_wdata = 8'h11; tick("R9");
    idle(); mem_addr = 16'hFEEF; tick("R9");
    // R2: an access in the command cycle uses the old bank
    sel_we = 1; sel_bank = 2'd1; cpu_we = 1; cpu_idx = 3'd0; cpu_wdata = 16'h0042; tick("R2");
    idle(); tick("R2");
    mem_addr = 16'hFEE8; tick("R2");
    mem_addr = 16'hFEF0; tick("R2");
    // Mixed pseudo-random traffic, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom % 4);
      sel_we    = ($urandom % 8) == 0;
      sel_bank  = 2'($urandom);
      cpu_we    = ($urandom % 3) == 0;
      cpu_wide  = 1'($urandom);
      cpu_idx   = 3'($urandom);
      cpu_wdata = 16'($urandom);
      mem_we    = ($urandom % 3) == 0;
      mem_wdata = 8'($urandom);
      mem_addr  = (r < 2) ? 16'(16'hFEE0 + $urandom % 32) :
                  (r == 2) ? 16'(16'hFEDC + $urandom % 40) : 16'($urandom);
      tick("R11");
    end
    idle();
    finish_run();
  end
endmodule